// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Controller

This block decides when a half-duplex Ethernet transmitter may put a frame on the line, and what happens when that frame meets a collision. It watches carrier sense and a per-bit-time tick. After the line has been quiet for a full inter-frame gap, it grants a pending frame by raising the transmit enable. While the frame is on the wire, it counts bit times. A collision makes it send a fixed jam burst. The collision is then classified by how far into the frame it occurred: an early collision leads to a random binary exponential backoff and a retry, while a late collision abandons the frame.

The host MAC holds its request high until the block reports the frame finished. The block reports this with a single-cycle pulse of one of three kinds: sent, dropped late, or dropped after too many attempts. The host marks the last bit of a frame with an end strobe. Serialization, CRC and the PHY sit outside this block.

Top module: `hdx_tx_ctrl`

## Requirements
- R1: Out of reset, every output is low and the gap counter is empty. With a request already pending and the line idle, the transmit enable rises at the clock edge that follows IPG_BITS counted ticks (IPG_BITS + 1 edges when a tick is present every cycle).
- R2: A start needs carrier sense low and the gap counter at IPG_BITS. Any cycle with carrier sense high, or with the block itself transmitting, empties the counter, so the full gap is counted again from the next quiet cycle.
- R3: The gap counter advances only on cycles with the bit tick high. With the tick held low, a pending frame never starts.
- R4: An end strobe during transmission with no collision in that cycle drops the transmit enable at the next edge, together with a one-cycle sent pulse. It also clears the attempt count.
- R5: A collision sampled while the frame's bit count (ticks since the start edge) is below SLOT_BITS is normal. Jam and transmit enable are then high for exactly JAM_BITS ticks, after which the frame is retried.
- R6: A collision sampled at a bit count of SLOT_BITS or more is late. Jam is sent for JAM_BITS ticks, and a one-cycle late-drop pulse is then raised with no retry.
- R7: After the n-th normal collision, the retry waits a random number of slots drawn from 0 to 2^min(n,BACKOFF_LIMIT)-1, each slot lasting SLOT_BITS ticks. The gap also applies, so the idle time before the retry lies between IPG_BITS and (2^min(n,BACKOFF_LIMIT)-1)*SLOT_BITS + IPG_BITS + 3 cycles.
- R8: When the MAX_ATTEMPTS-th consecutive attempt of a frame ends in a normal collision, no backoff follows. A one-cycle excess-drop pulse is raised instead and the attempt count returns to zero.
- R9: When a collision and the end strobe fall in the same cycle, the collision wins: jam follows and no sent pulse is raised. Carrier sense and collisions are ignored outside transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bit time on the line |
| crs | input | 1 | Carrier sense from the PHY |
| col | input | 1 | Collision indication from the PHY |
| tx_req | input | 1 | Frame pending, held until a completion pulse |
| tx_end | input | 1 | Last bit of the frame is being sent |
| tx_en | output | 1 | Transmitter owns the line (data or jam) |
| jam | output | 1 | Send the jam pattern instead of frame data |
| done | output | 1 | One-cycle pulse: frame sent |
| drop_late | output | 1 | One-cycle pulse: frame dropped after a late collision |
| drop_excess | output | 1 | One-cycle pulse: frame dropped after too many attempts |

## Verification
Two functions can meet in one cycle: the end of a frame and collision detection. The bench drives the end strobe and the collision together, once at a bit count below the slot boundary and once exactly on it. It then expects a full jam and either a retry or a late drop, and never a sent pulse. The slot boundary is also probed from both sides, with collisions at bit counts SLOT_BITS-1 and SLOT_BITS, to pin down where normal ends and late begins.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TX      = 2'd1,
        ST_JAM     = 2'd2,
        ST_BACKOFF = 2'd3
    } tx_state_e;
endpackage

// File: rtl/hdx_gap_timer.sv
module hdx_gap_timer #(
    parameter int IPG_BITS = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic line_busy,
    output logic gap_ok
);
    localparam int CNT_W = $clog2(IPG_BITS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } gap_regs_t;

    gap_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (line_busy) begin
            r_d.cnt = '0;
        end else if (bit_tick && (r_q.cnt != CNT_W'(IPG_BITS))) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign gap_ok = (r_q.cnt == CNT_W'(IPG_BITS));

    // R2: a busy line always leaves the gap open on the next cycle
    assert_busy_reopens_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_busy |=> !gap_ok);
endmodule

// File: rtl/hdx_backoff.sv
module hdx_backoff #(
    parameter int              SLOT_BITS     = 512,
    parameter int              BACKOFF_LIMIT = 10,
    parameter int              ATT_W         = 5,
    parameter int              LFSR_W        = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS   = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED   = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             load,
    input  logic [ATT_W-1:0] attempt,
    output logic             busy
);
    localparam int REM_W = BACKOFF_LIMIT;
    localparam int SUB_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [REM_W-1:0]  rem;
        logic [SUB_W-1:0]  sub;
        logic              active;
    } bo_regs_t;

    bo_regs_t          r_d, r_q;
    logic [REM_W-1:0]  mask;
    int                exp_k;

    always_comb begin
        exp_k = (int'(attempt) > BACKOFF_LIMIT) ? BACKOFF_LIMIT : int'(attempt);
        for (int i = 0; i < REM_W; i++) begin
            mask[i] = (i < exp_k);
        end
    end

    always_comb begin
        r_d = r_q;
        r_d.lfsr = {1'b0, r_q.lfsr[LFSR_W-1:1]} ^ (r_q.lfsr[0] ? LFSR_TAPS : '0);
        if (load) begin
            r_d.rem    = r_q.lfsr[REM_W-1:0] & mask;
            r_d.sub    = '0;
            r_d.active = 1'b1;
        end else if (r_q.active) begin
            if (r_q.rem == '0) begin
                r_d.active = 1'b0;
            end else if (bit_tick) begin
                if (r_q.sub == SUB_W'(SLOT_BITS - 1)) begin
                    r_d.sub = '0;
                    r_d.rem = r_q.rem - 1'b1;
                end else begin
                    r_d.sub = r_q.sub + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.lfsr <= LFSR_SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = r_q.active;

    // R7: the drawn slot count never exceeds the window for this attempt
    assert_slot_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((r_q.rem & ~$past(mask)) == '0));
    // R7: the random source never locks up at zero
    assert_lfsr_alive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.lfsr != '0);
endmodule

// File: rtl/hdx_tx_ctrl.sv
module hdx_tx_ctrl #(
    parameter int IPG_BITS      = 96,
    parameter int SLOT_BITS     = 512,
    parameter int JAM_BITS      = 32,
    parameter int BACKOFF_LIMIT = 10,
    parameter int MAX_ATTEMPTS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic crs,
    input  logic col,
    input  logic tx_req,
    input  logic tx_end,
    output logic tx_en,
    output logic jam,
    output logic done,
    output logic drop_late,
    output logic drop_excess
);
    import hdx_pkg::*;

    localparam int BIT_W = $clog2(SLOT_BITS + 1);
    localparam int JAM_W = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);

    typedef struct packed {
        tx_state_e        st;
        logic [BIT_W-1:0] bit_cnt;
        logic [JAM_W-1:0] jam_cnt;
        logic             late;
        logic [ATT_W-1:0] attempts;
        logic             done;
        logic             drop_late;
        logic             drop_excess;
    } ctl_regs_t;

    ctl_regs_t        r_d, r_q;
    logic             gap_ok;
    logic             bo_load;
    logic             bo_busy;
    logic [ATT_W-1:0] attempt_n;

    assign attempt_n = r_q.attempts + 1'b1;
    assign tx_en     = (r_q.st == ST_TX) || (r_q.st == ST_JAM);
    assign jam       = (r_q.st == ST_JAM);
    assign done        = r_q.done;
    assign drop_late   = r_q.drop_late;
    assign drop_excess = r_q.drop_excess;

    hdx_gap_timer #(
        .IPG_BITS (IPG_BITS)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .line_busy (crs | tx_en),
        .gap_ok    (gap_ok)
    );

    hdx_backoff #(
        .SLOT_BITS     (SLOT_BITS),
        .BACKOFF_LIMIT (BACKOFF_LIMIT),
        .ATT_W         (ATT_W)
    ) u_backoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .load     (bo_load),
        .attempt  (attempt_n),
        .busy     (bo_busy)
    );

    always_comb begin
        r_d             = r_q;
        r_d.done        = 1'b0;
        r_d.drop_late   = 1'b0;
        r_d.drop_excess = 1'b0;
        bo_load         = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (tx_req && gap_ok && !crs) begin
                    r_d.st      = ST_TX;
                    r_d.bit_cnt = '0;
                end
            end
            ST_TX: begin
                if (col) begin
                    r_d.st      = ST_JAM;
                    r_d.jam_cnt = '0;
                    r_d.late    = (r_q.bit_cnt >= BIT_W'(SLOT_BITS));
                end else if (tx_end) begin
                    r_d.st       = ST_IDLE;
                    r_d.done     = 1'b1;
                    r_d.attempts = '0;
                end else if (bit_tick && (r_q.bit_cnt != BIT_W'(SLOT_BITS))) begin
                    r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                end
            end
            ST_JAM: begin
                if (bit_tick) begin
                    if (r_q.jam_cnt == JAM_W'(JAM_BITS - 1)) begin
                        if (r_q.late) begin
                            r_d.st        = ST_IDLE;
                            r_d.drop_late = 1'b1;
                            r_d.attempts  = '0;
                        end else if (r_q.attempts == ATT_W'(MAX_ATTEMPTS - 1)) begin
                            r_d.st          = ST_IDLE;
                            r_d.drop_excess = 1'b1;
                            r_d.attempts    = '0;
                        end else begin
                            r_d.st       = ST_BACKOFF;
                            r_d.attempts = attempt_n;
                            bo_load      = 1'b1;
                        end
                    end else begin
                        r_d.jam_cnt = r_q.jam_cnt + 1'b1;
                    end
                end
            end
            ST_BACKOFF: begin
                if (!bo_busy) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: a frame starts only after the gap timer reported a full gap
    assert_start_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> ($past(gap_ok) && !$past(crs)));
    // R5: jam begins only in response to a sampled collision
    assert_jam_after_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam) |-> $past(col));
    // R6: a late drop is always preceded by jam
    assert_late_after_jam_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drop_late |-> $past(jam));
    // R4: at most one completion pulse at a time
    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, drop_late, drop_excess}));
    // R8: attempt count stays below the abandon limit
    assert_attempt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.attempts < ATT_W'(MAX_ATTEMPTS));
    // R9: a sent pulse never follows a cycle that saw a collision
    assert_col_beats_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(tx_en) && !$past(jam) && !$past(col)));
endmodule

// File: tb/hdx_tx_ctrl_test.sv
module hdx_tx_ctrl_test;
    localparam int IPG  = 6;
    localparam int SLOT = 8;
    localparam int JAML = 4;
    localparam int LIM  = 3;
    localparam int MAXA = 16;

    localparam int O_DONE = 0, O_RETRY = 1, O_LATE = 2, O_EXCESS = 3, O_ERR = 4;

    // columns: collision bit count (-1 none), frame length, expected outcome, coincident end
    localparam int NVEC = 8;
    localparam int VEC [NVEC][4] = '{
        '{-1,        5,  O_DONE,  0},
        '{-1,        20, O_DONE,  0},
        '{0,         20, O_RETRY, 0},
        '{SLOT - 1,  20, O_RETRY, 0},
        '{SLOT,      20, O_LATE,  0},
        '{SLOT + 7,  20, O_LATE,  0},
        '{4,         5,  O_RETRY, 1},
        '{SLOT,      SLOT + 1, O_LATE, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b1;
    logic crs = 1'b0;
    logic col = 1'b0;
    logic tx_req = 1'b0;
    logic tx_end = 1'b0;
    logic tx_en, jam, done, drop_late, drop_excess;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    hdx_tx_ctrl #(
        .IPG_BITS (IPG), .SLOT_BITS (SLOT), .JAM_BITS (JAML),
        .BACKOFF_LIMIT (LIM), .MAX_ATTEMPTS (MAXA)
    ) uut (
        .clk (clk), .rst_n (rst_n), .bit_tick (bit_tick), .crs (crs),
        .col (col), .tx_req (tx_req), .tx_end (tx_end), .tx_en (tx_en),
        .jam (jam), .done (done), .drop_late (drop_late), .drop_excess (drop_excess)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_start(output int idle_n);
        idle_n = 0;
        for (int g = 0; g < 3000; g++) begin
            @(negedge clk);
            if (tx_en) break;
            idle_n++;
        end
    endtask

    task automatic run_frame(input int col_at, input int len,
                             output int outcome, output int jam_len);
        outcome = O_ERR;
        jam_len = 0;
        for (int k = 0; k < 1000; k++) begin
            col    = (k == col_at);
            tx_end = (k == len - 1);
            @(negedge clk);
            col    = 1'b0;
            tx_end = 1'b0;
            if (jam) begin
                for (int j = 0; j < 1000 && jam; j++) begin
                    jam_len++;
                    @(negedge clk);
                end
                outcome = drop_late ? O_LATE : (drop_excess ? O_EXCESS : O_RETRY);
                if (done) outcome = O_ERR;
                return;
            end
            if (done) begin
                outcome = O_DONE;
                return;
            end
            if (!tx_en) return;
        end
    endtask

    function automatic int bo_bound(input int n);
        int k;
        k = (n > LIM) ? LIM : n;
        return ((1 << k) - 1) * SLOT + IPG + 3;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        int idle, outc, jl;
        string tag;

        // R1: reset state and first gap
        repeat (3) @(negedge clk);
        chk("R1 tx_en in reset", int'(tx_en), 0);
        chk("R1 jam in reset", int'(jam), 0);
        chk("R1 pulses in reset", int'(done | drop_late | drop_excess), 0);
        tx_req = 1'b1;
        rst_n  = 1'b1;
        wait_start(idle);
        chk("R1 first gap", idle, IPG);
        run_frame(-1, 3, outc, jl);
        chk("R1 first frame sent", outc, O_DONE);
        tx_req = 1'b0;

        // R2: carrier defers, a carrier blip restarts the gap
        tx_req = 1'b1;
        crs    = 1'b1;
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk("R2 deferred under carrier", int'(tx_en), 0);
        crs = 1'b0;
        for (int i = 0; i < IPG - 2; i++) @(negedge clk);
        crs = 1'b1;
        @(negedge clk);
        chk("R9 carrier ignored outside tx", int'(tx_en | jam), 0);
        crs = 1'b0;
        wait_start(idle);
        chk("R2 gap restarted", idle, IPG);
        run_frame(-1, 4, outc, jl);
        chk("R2 frame sent", outc, O_DONE);
        tx_req = 1'b0;

        // R3: no tick, no gap progress
        bit_tick = 1'b0;
        tx_req   = 1'b1;
        col      = 1'b1;
        for (int i = 0; i < 3 * IPG; i++) @(negedge clk);
        col = 1'b0;
        chk("R3 no start without ticks", int'(tx_en), 0);
        chk("R9 idle collision ignored", int'(jam), 0);
        bit_tick = 1'b1;
        wait_start(idle);
        chk("R3 gap counts ticks only", idle, IPG);
        run_frame(-1, 2, outc, jl);
        chk("R3 frame sent", outc, O_DONE);
        tx_req = 1'b0;

        // vector table: R4 R5 R6 R7 R9
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][3] != 0)           tag = "R9";
            else if (VEC[v][2] == O_DONE) tag = "R4";
            else if (VEC[v][2] == O_LATE) tag = "R6";
            else                          tag = "R5";
            tx_req = 1'b1;
            wait_start(idle);
            chk({tag, " gap before start"}, int'(idle >= IPG), 1);
            run_frame(VEC[v][0], VEC[v][1], outc, jl);
            chk({tag, " outcome"}, outc, VEC[v][2]);
            if (VEC[v][2] != O_DONE) chk({tag, " jam length"}, jl, JAML);
            if (outc == O_RETRY) begin
                wait_start(idle);
                chk("R7 retry not before gap", int'(idle >= IPG), 1);
                chk("R7 retry within window n=1", int'(idle <= bo_bound(1)), 1);
                run_frame(-1, VEC[v][1], outc, jl);
                chk("R5 retry completes", outc, O_DONE);
            end
            tx_req = 1'b0;
        end

        // R8: every attempt collides
        tx_req = 1'b1;
        for (int a = 1; a <= MAXA; a++) begin
            wait_start(idle);
            if (a > 1) chk("R7 backoff window", int'(idle <= bo_bound(a - 1)), 1);
            run_frame(0, 20, outc, jl);
            if (a < MAXA) chk("R8 retry before limit", outc, O_RETRY);
            else          chk("R8 excess drop", outc, O_EXCESS);
            if (outc != O_RETRY) break;
        end
        tx_req = 1'b0;
        @(negedge clk);
        chk("R8 no attempt after drop", int'(tx_en), 0);

        // R8: attempt count cleared, next collision uses the first window
        tx_req = 1'b1;
        wait_start(idle);
        run_frame(2, 20, outc, jl);
        chk("R8 fresh frame collides", outc, O_RETRY);
        wait_start(idle);
        chk("R8 counter restarted window", int'(idle <= bo_bound(1)), 1);
        run_frame(-1, 6, outc, jl);
        chk("R4 fresh frame sent", outc, O_DONE);
        tx_req = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule